// File: doc/BRIEF.md
# Entropy Sampling and Refill Controller

This block turns a single-bit noise input into 64-bit random words that software reads over a small 32-bit register bus. The noise input passes through a two-stage synchronizer. It is then sampled once every (divider+1) clock cycles. Each sample shifts into a 64-bit collection register. Once enabled, the engine first runs a warm-up period of a programmed number of samples. It then copies the collection register into two output words and raises a ready flag. Software reads both words and writes an acknowledge. The acknowledge drops the flag and starts a refill period, after which a new word is published.

The engine is a four-state machine. ST_IDLE is entered whenever the enable bit is 0. ST_IDLE goes to ST_WARMUP when enable is seen high. ST_WARMUP goes to ST_HOLD on the sample that completes the warm-up count. ST_HOLD goes to ST_REFILL on an acknowledge. ST_REFILL goes to ST_HOLD on the sample that completes the refill count. An interrupt output mirrors the ready flag, gated by a mask bit.

Top module: `entropy_collector`

## Requirements
- R1: Registers sit at byte offsets 0x00 output low word, 0x04 output high word, 0x08 status, 0x0C interrupt mask, 0x10 acknowledge, 0x14 control, 0x18 config. The acknowledge register, unused offsets and unimplemented bits read as zero. Control reads back only bit 10 and bits [23:16]. Config reads back bits [23:0]. The mask reads back bit 0.
- R2: Control bit 10 enables the engine. While it is 0 the engine sits in ST_IDLE and ready is low. Setting it again restarts a full warm-up period.
- R3: Control bits [23:16] give the warm-up count. A nonzero value N means N*256 samples. Ready rises 1 + samples*(divider+1) clock edges after the edge that writes the enable.
- R4: A zero in any count field means 2^FULL_LOG2 samples (FULL_LOG2 defaults to 24).
- R5: The refill length is the larger of two values: config bits [23:16] as the maximum count (N*256), and config bits [7:0] as the minimum floor (N*64).
- R6: Config bits [15:8] hold the divider d. One sample is taken every d+1 clock cycles.
- R7: Writing 1 to bit 0 of the acknowledge register while ready is high clears ready. Ready rises again 1 + refill*(d+1) edges after the acknowledge write edge.
- R8: The irq output equals ready ANDed with mask bit 0.
- R9: The output words stay frozen while ready is high. On the cycle ready rises they take the most recent 64 samples, with the newest sample in bit 0 of the low word.
- R10: An acknowledge written while ready is low has no effect on the period in progress.
- R11: Status bit 0 reads the ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| noise_in | input | 1 | Asynchronous entropy bit |
| irq | output | 1 | Masked ready interrupt |

## Verification
The noise input is driven in three ways. Held at 1 and held at 0, it gives exact all-ones and all-zeros words. These separate a correct latch of fresh samples from a stale or frozen output. A bench LFSR stub produces changing words, which shows that successive results are not copies. Period lengths are measured edge-exact across several settings: warm-up against refill, divider 0 against 2, maximum count against a larger minimum floor, and zero encodings. Each setting separates one counting rule from its neighbours. Acknowledges written during warm-up, and disable during hold, check that stimulus outside ST_HOLD neither shortens nor extends a period.

// File: rtl/egen_pkg.sv
package egen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WARMUP = 2'd1,
        ST_REFILL = 2'd2,
        ST_HOLD   = 2'd3
    } eng_state_t;

    // register word index (byte offset / 4)
    localparam logic [2:0] IDX_OUT_LO = 3'd0;
    localparam logic [2:0] IDX_OUT_HI = 3'd1;
    localparam logic [2:0] IDX_STATUS = 3'd2;
    localparam logic [2:0] IDX_MASK   = 3'd3;
    localparam logic [2:0] IDX_ACK    = 3'd4;
    localparam logic [2:0] IDX_CTRL   = 3'd5;
    localparam logic [2:0] IDX_CFG    = 3'd6;

    localparam int CTL_EN_BIT    = 10;
    localparam int CNT_FIELD_W   = 8;
    localparam int WARMUP_SHIFT  = 8;
    localparam int MAXREF_SHIFT  = 8;
    localparam int MINREF_SHIFT  = 6;

endpackage

// File: rtl/egen_regs.sv
module egen_regs
    import egen_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ready,
    input  logic [63:0]       word,
    output logic              ctl_en,
    output logic [7:0]        warm_n,
    output logic [7:0]        min_n,
    output logic [7:0]        div_n,
    output logic [7:0]        max_n,
    output logic              mask0,
    output logic              ack_pulse
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic             wr_en;
    logic             unused_bits;

    assign idx         = bus_addr[ADDR_W-1:2];
    assign wr_en       = bus_sel && bus_wr;
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:24]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            warm_n    <= '0;
            min_n     <= '0;
            div_n     <= '0;
            max_n     <= '0;
            mask0     <= 1'b0;
            ack_pulse <= 1'b0;
        end else begin
            ack_pulse <= wr_en && (idx == IDX_W'(IDX_ACK)) && bus_wdata[0];
            if (wr_en) begin
                unique case (idx)
                    IDX_W'(IDX_CTRL): begin
                        ctl_en <= bus_wdata[CTL_EN_BIT];
                        warm_n <= bus_wdata[23:16];
                    end
                    IDX_W'(IDX_CFG): begin
                        min_n <= bus_wdata[7:0];
                        div_n <= bus_wdata[15:8];
                        max_n <= bus_wdata[23:16];
                    end
                    IDX_W'(IDX_MASK): mask0 <= bus_wdata[0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            unique case (idx)
                IDX_W'(IDX_OUT_LO): bus_rdata = word[31:0];
                IDX_W'(IDX_OUT_HI): bus_rdata = word[63:32];
                IDX_W'(IDX_STATUS): bus_rdata = {31'b0, ready};
                IDX_W'(IDX_MASK):   bus_rdata = {31'b0, mask0};
                IDX_W'(IDX_CTRL):   bus_rdata = {8'b0, warm_n, 5'b0, ctl_en, 10'b0};
                IDX_W'(IDX_CFG):    bus_rdata = {8'b0, max_n, div_n, min_n};
                default:            bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/egen_sampler.sv
module egen_sampler #(
    parameter int DIV_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             noise_in,
    input  logic             running,
    input  logic [DIV_W-1:0] div_n,
    output logic             tick,
    output logic             sample_bit
);

    logic [SYNC_N-1:0] sync_q;
    logic [DIV_W-1:0]  div_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_N; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= noise_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign sample_bit = sync_q[SYNC_N-1];
    assign tick       = running && (div_q >= div_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (!running || tick) div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/egen_engine.sv
module egen_engine
    import egen_pkg::*;
#(
    parameter int FULL_LOG2 = 24,
    parameter int CNT_W     = 25,
    parameter int WORD_W    = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ack,
    input  logic              tick,
    input  logic              sample_bit,
    input  logic [7:0]        warm_n,
    input  logic [7:0]        min_n,
    input  logic [7:0]        max_n,
    output logic              sampling,
    output logic              ready,
    output logic [WORD_W-1:0] word
);

    eng_state_t        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] shreg_q;
    logic [CNT_W-1:0]  warm_len, min_len, max_len, refill_len;
    logic              last_tick;

    function automatic logic [CNT_W-1:0] decode_len(input logic [7:0] n, input int sh);
        logic [CNT_W-1:0] r;
        if (n == 8'd0) r = CNT_W'(1) << FULL_LOG2;
        else           r = CNT_W'(n) << sh;
        return r;
    endfunction

    assign warm_len   = decode_len(warm_n, WARMUP_SHIFT);
    assign min_len    = decode_len(min_n, MINREF_SHIFT);
    assign max_len    = decode_len(max_n, MAXREF_SHIFT);
    assign refill_len = (min_len > max_len) ? min_len : max_len;

    assign sampling  = (state_q == ST_WARMUP) || (state_q == ST_REFILL);
    assign last_tick = sampling && tick && (cnt_q == CNT_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (en) state_d = ST_WARMUP;
            ST_WARMUP: if (last_tick) state_d = ST_HOLD;
            ST_REFILL: if (last_tick) state_d = ST_HOLD;
            ST_HOLD:   if (ack) state_d = ST_REFILL;
            default:   state_d = ST_IDLE;
        endcase
        if (!en) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // counter, collection register and published word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
            word    <= '0;
        end else begin
            if (state_q == ST_IDLE && state_d == ST_WARMUP)
                cnt_q <= warm_len;
            else if (state_q == ST_HOLD && state_d == ST_REFILL)
                cnt_q <= refill_len;
            else if (sampling && tick)
                cnt_q <= cnt_q - 1'b1;

            if (sampling && tick)
                shreg_q <= {shreg_q[WORD_W-2:0], sample_bit};

            if (last_tick && en)
                word <= {shreg_q[WORD_W-2:0], sample_bit};
        end
    end

    // outputs
    always_comb begin
        ready = (state_q == ST_HOLD);
    end

endmodule

// File: rtl/entropy_collector.sv
module entropy_collector #(
    parameter int FULL_LOG2 = 24,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter int SYNC_N    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              noise_in,
    output logic              irq
);

    localparam int CNT_W  = ((FULL_LOG2 > 16) ? FULL_LOG2 : 16) + 1;
    localparam int WORD_W = 2 * DATA_W;

    logic              ctl_en, mask0, ack_pulse;
    logic [7:0]        warm_n, min_n, div_n, max_n;
    logic              eng_ready, sampling, tick, sample_bit;
    logic [WORD_W-1:0] eng_word;

    egen_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ready(eng_ready), .word(eng_word),
        .ctl_en(ctl_en), .warm_n(warm_n), .min_n(min_n), .div_n(div_n),
        .max_n(max_n), .mask0(mask0), .ack_pulse(ack_pulse)
    );

    egen_sampler #(.DIV_W(8), .SYNC_N(SYNC_N)) u_samp (
        .clk(clk), .rst_n(rst_n), .noise_in(noise_in), .running(sampling),
        .div_n(div_n), .tick(tick), .sample_bit(sample_bit)
    );

    egen_engine #(.FULL_LOG2(FULL_LOG2), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(ctl_en), .ack(ack_pulse), .tick(tick),
        .sample_bit(sample_bit), .warm_n(warm_n), .min_n(min_n), .max_n(max_n),
        .sampling(sampling), .ready(eng_ready), .word(eng_word)
    );

    assign irq = eng_ready & mask0;

endmodule

// File: rtl/egen_checker.sv
module egen_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        ack,
    input logic        ready,
    input logic        irq,
    input logic [63:0] word
);

    AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !ready); // R2

    AST_RISE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(en)); // R2

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ready) |=> !ready); // R7

    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready); // R8

    AST_OUT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (!ready || $stable(word))); // R9

endmodule

bind entropy_collector egen_checker u_chk (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .ack(ack_pulse),
    .ready(eng_ready), .irq(irq), .word(eng_word)
);

// File: tb/sim_entropy_collector.sv
module sim_entropy_collector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        noise_in;
    logic        irq;
    logic        noise_const = 1'b1;
    logic        lfsr_on = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int          errors = 0;
    int          checks = 0;

    localparam int SMALL_LOG2 = 10;
    localparam logic [31:0] EN = 32'h0000_0400;

    always #10 clk = ~clk;

    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    assign noise_in = lfsr_on ? lfsr[0] : noise_const;

    entropy_collector #(.FULL_LOG2(SMALL_LOG2)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .noise_in(noise_in), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_sel = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // counts edges from the last write edge until status bit 0 reads 1
    task automatic poll(input int limit, input int ack_at, output int n_out);
        n_out = 0;
        for (int n = 1; n <= limit; n++) begin
            @(negedge clk);
            bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 5'h08;
            #1;
            if (bus_rdata[0]) begin
                n_out = n;
                break;
            end
            if (n == ack_at) begin
                bus_wr = 1'b1; bus_addr = 5'h10; bus_wdata = 32'h1;
            end
        end
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(5'h08, d); chk(d == 0, "R11 status after reset", d, 0);
        rd(5'h14, d); chk(d == 0, "R1 control after reset", d, 0);
        chk(irq == 0, "R8 irq after reset", irq, 0);
    endtask

    task automatic t_regmap;
        logic [31:0] d;
        wr(5'h18, 32'hFF0A_0B0C);
        rd(5'h18, d); chk(d == 32'h000A_0B0C, "R1 config readback", d, 32'h000A_0B0C);
        wr(5'h14, 32'hFFFF_FBFF);
        rd(5'h14, d); chk(d == 32'h00FF_0000, "R1 control readback", d, 32'h00FF_0000);
        wr(5'h0C, 32'hFFFF_FFFE);
        rd(5'h0C, d); chk(d == 0, "R1 mask readback", d, 0);
        rd(5'h10, d); chk(d == 0, "R1 ack reads zero", d, 0);
        rd(5'h1C, d); chk(d == 0, "R1 unused offset", d, 0);
        rd(5'h08, d); chk(d == 0, "R2 disabled not ready", d, 0);
        wr(5'h14, 32'h0);
    endtask

    task automatic t_startup;
        logic [31:0] lo, hi;
        int n;
        noise_const = 1'b1;
        wr(5'h18, 32'h0001_0001);
        wr(5'h14, EN | (32'd1 << 16));
        poll(5000, 0, n); chk(n == 257, "R3 warm-up latency", n, 257);
        rd(5'h00, lo); rd(5'h04, hi);
        chk({hi, lo} == '1, "R9 ones word", {hi, lo}, '1);
        chk(irq == 0, "R8 irq masked", irq, 0);
        wr(5'h0C, 32'h1);
        #1 chk(irq == 1, "R8 irq unmasked", irq, 1);
    endtask

    task automatic t_frozen;
        logic [31:0] lo, st;
        noise_const = 1'b0;
        repeat (100) @(negedge clk);
        rd(5'h08, st); chk(st == 1, "R11 still ready", st, 1);
        rd(5'h00, lo); chk(lo == 32'hFFFF_FFFF, "R9 frozen word", lo, 32'hFFFF_FFFF);
    endtask

    task automatic t_refill;
        logic [31:0] lo, hi;
        int n;
        wr(5'h10, 32'h1);
        poll(5000, 0, n); chk(n == 257, "R7 refill latency", n, 257);
        rd(5'h00, lo); rd(5'h04, hi);
        chk({hi, lo} == 0, "R9 fresh zero word", {hi, lo}, 0);
    endtask

    task automatic t_divider;
        int n;
        wr(5'h18, 32'h0001_0201);
        wr(5'h10, 32'h1);
        poll(5000, 0, n); chk(n == 769, "R6 divider 2 latency", n, 769);
    endtask

    task automatic t_minfloor;
        int n;
        wr(5'h18, 32'h0001_0008);
        wr(5'h10, 32'h1);
        poll(5000, 0, n); chk(n == 513, "R5 minimum floor", n, 513);
        wr(5'h18, 32'h0001_0001);
    endtask

    task automatic t_disable;
        logic [31:0] st;
        int n;
        wr(5'h14, 32'h0001_0000);
        @(negedge clk);
        rd(5'h08, st); chk(st == 0, "R2 disable drops ready", st, 0);
        chk(irq == 0, "R8 irq low when disabled", irq, 0);
        repeat (600) @(negedge clk);
        rd(5'h08, st); chk(st == 0, "R2 idle stays low", st, 0);
        wr(5'h14, EN | (32'd1 << 16));
        poll(5000, 0, n); chk(n == 257, "R2 re-enable restarts warm-up", n, 257);
    endtask

    task automatic t_ack_ignored;
        int n;
        wr(5'h14, 32'h0);
        wr(5'h14, EN | (32'd1 << 16));
        poll(5000, 10, n); chk(n == 257, "R10 ack during warm-up ignored", n, 257);
    endtask

    task automatic t_zero;
        int n;
        wr(5'h14, 32'h0);
        wr(5'h14, EN);
        poll(5000, 0, n); chk(n == 1025, "R4 zero warm-up count", n, 1025);
        wr(5'h18, 32'h0000_0001);
        wr(5'h10, 32'h1);
        poll(5000, 0, n); chk(n == 1025, "R4 zero refill count", n, 1025);
        wr(5'h18, 32'h0001_0001);
    endtask

    task automatic t_lfsr;
        logic [31:0] lo, hi;
        logic [63:0] w1;
        int n;
        lfsr_on = 1'b1;
        wr(5'h10, 32'h1);
        poll(5000, 0, n); chk(n == 257, "R7 refill with lfsr", n, 257);
        rd(5'h00, lo); rd(5'h04, hi); w1 = {hi, lo};
        chk(w1 != 0 && w1 != '1, "R9 lfsr word mixed", w1, 0);
        wr(5'h10, 32'h1);
        poll(5000, 0, n);
        rd(5'h00, lo); rd(5'h04, hi);
        chk({hi, lo} != w1, "R9 successive words differ", {hi, lo}, w1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_startup();
        t_frozen();
        t_refill();
        t_divider();
        t_minfloor();
        t_disable();
        t_ack_ignored();
        t_zero();
        t_lfsr();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule